// File: doc/BRIEF.md
# Quad-Pumped Inverting Data-Path Transmitter and Receiver

This block drives a 64-bit data path on active-low wires, moving four 64-bit sub-phase transfers in each bus clock. Each bus clock is modelled as four beats of a 4x clock. A payload source hands over a 256-bit word through a valid/ready handshake. In the following bus clock the block puts the four sub-phases on the wires in order. The 64 bits form four 16-bit groups. In every sub-phase, each group is inverted on its own whenever more than half of its wires would otherwise be pulled electrically low. Each group has an inversion flag and a parity bit that travel with its data.

A data-ready output marks every bus clock that carries data. A bus-busy output frames a whole multi-clock transfer. When the source has no payload at a clock boundary during a transfer, the block inserts an idle clock: data-ready is low and the wires are released, but bus-busy stays high. Bus-busy drops only after the clock that carries the payload marked as final.

The same block contains the matching receiver. It takes wires, flags, parity and a ready qualifier, restores the true data of each group, and flags a parity mismatch for each group in each sub-phase.

Top module: `qpDataLink`

## Requirements
- R1: While reset is held and just after it is released, dataRdy and busBusy are 0, every busWire bit is 1 (released), and busInv and busPar are 0.
- R2: payReady is 1 only on the fourth beat of each bus clock, which is every fourth 4x-clock cycle. A payload is accepted on a rising edge where payValid and payReady are both 1.
- R3: Sub-phase k of an accepted payload is payData[64k+63:64k]. It is driven on beat k (k = 0..3, in that order) of the bus clock that follows acceptance.
- R4: Group g covers bits [16g+15:16g] and owns busInv[g]. In each sub-phase, busInv[g] is 1 exactly when the true data of group g has more than 8 bits set to 1.
- R5: A true 1 is carried as an electrical low (wire value 0). A group with its flag at 0 drives the complement of its true bits. A group with its flag at 1 drives its true bits unchanged.
- R6: busPar[g] equals the XOR of the 16 busWire bits of group g, as they appear after inversion.
- R7: dataRdy is 1 on all four beats of a bus clock that carries an accepted payload, and 0 otherwise. On a clock with no data, all wires are 1 and all flags are 0.
- R8: busBusy rises with the first data clock and stays 1 through idle clocks inserted inside a transfer. It falls at the start of the clock after the one carrying a payload accepted with payLast = 1, unless a new payload was accepted for that clock.
- R9: The receiver outputs rxData group g as rxWire group g when rxInv[g] is 1, and as its complement when rxInv[g] is 0.
- R10: rxParErr[g] is 1 exactly when rxRdy is 1 and rxPar[g] differs from the XOR of the 16 rxWire bits of group g. When rxRdy is 0, it is 0 regardless of the wires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4x clock, one beat per sub-phase |
| rstN | input | 1 | Active-low synchronous reset |
| payValid | input | 1 | Source offers a 256-bit payload |
| payData | input | 256 | Four sub-phases, sub-phase k in bits [64k+63:64k] |
| payLast | input | 1 | Offered payload is the final one of the transfer |
| payReady | output | 1 | Payload accepted on this edge if valid |
| busWire | output | 64 | Active-low data wires after inversion |
| busInv | output | 4 | Per-group inversion flag |
| busPar | output | 4 | Per-group parity over the driven wires |
| dataRdy | output | 1 | Current bus clock carries valid data |
| busBusy | output | 1 | Data bus is held for a transfer |
| rxWire | input | 64 | Receiver wire inputs |
| rxInv | input | 4 | Receiver per-group inversion flags |
| rxPar | input | 4 | Receiver per-group parity bits |
| rxRdy | input | 1 | Receiver qualifier: wires carry data |
| rxData | output | 64 | Restored true data |
| rxParErr | output | 4 | Per-group parity mismatch |

## Verification
On every cycle, the assertions check four things: no group carrying data ever has more than half its wires low, a raised flag always comes with a majority of set wires, idle clocks release the wires, and the handshake pulses and busy framing relate correctly. The bench is needed to show the exact threshold at 8 versus 9 set bits, the sub-phase order, true-data recovery through the receiver, and parity errors from a corrupted wire being reported only while rxRdy is high. The bench loops the transmitter back into the receiver and sweeps the set-bit count of every group through all 17 values, with different bit positions in each sub-phase.

// File: rtl/qpLinkPkg.sv
package qpLinkPkg;
  localparam int QP_BEATS = 4;
  localparam int QP_SEL_W = $clog2(QP_BEATS);

  typedef struct packed {
    logic                load;   // capture payload this edge
    logic                drive;  // current bus clock carries data
    logic [QP_SEL_W-1:0] sel;    // sub-phase on the wires
  } qpStrobe_t;
endpackage

// File: rtl/qpGroupEnc.sv
module qpGroupEnc #(
  parameter int GROUP_W = 16
) (
  input  logic [GROUP_W-1:0] trueBits,
  output logic [GROUP_W-1:0] wireBits,
  output logic               invert
);
  localparam int CNT_W = $clog2(GROUP_W + 1);

  logic [CNT_W-1:0] onesCnt;

  always_comb begin
    onesCnt = '0;
    for (int i = 0; i < GROUP_W; i++) begin
      onesCnt = onesCnt + CNT_W'(trueBits[i]);
    end
  end

  // a true 1 is an electrical low; flip when lows would be the majority
  assign invert   = onesCnt > CNT_W'(GROUP_W / 2);
  assign wireBits = invert ? trueBits : ~trueBits;
endmodule

// File: rtl/qpLinkCtrl.sv
module qpLinkCtrl
  import qpLinkPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      payValid,
  input  logic      payLast,
  output logic      payReady,
  output logic      dataRdy,
  output logic      busBusy,
  output qpStrobe_t strobe
);
  logic [QP_SEL_W-1:0] beat;
  logic                curValid;
  logic                lastHeld;
  logic                busyReg;
  logic                lastBeat;
  logic                accept;

  assign lastBeat = beat == QP_SEL_W'(QP_BEATS - 1);
  assign accept   = payValid & lastBeat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beat     <= '0;
      curValid <= 1'b0;
      lastHeld <= 1'b0;
      busyReg  <= 1'b0;
    end else begin
      beat <= beat + 1'b1;
      if (lastBeat) begin
        curValid <= accept;
        if (accept) lastHeld <= payLast;
        busyReg <= accept | (busyReg & ~(curValid & lastHeld));
      end
    end
  end

  assign payReady     = lastBeat;
  assign dataRdy      = curValid;
  assign busBusy      = busyReg;
  assign strobe.load  = accept;
  assign strobe.drive = curValid;
  assign strobe.sel   = beat;
endmodule

// File: rtl/qpLinkDatapath.sv
module qpLinkDatapath
  import qpLinkPkg::*;
#(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  qpStrobe_t                           strobe,
  input  logic [GROUPS*GROUP_W*QP_BEATS-1:0]  payData,
  output logic [GROUPS*GROUP_W-1:0]           busWire,
  output logic [GROUPS-1:0]                   busInv,
  output logic [GROUPS-1:0]                   busPar,
  input  logic [GROUPS*GROUP_W-1:0]           rxWire,
  input  logic [GROUPS-1:0]                   rxInv,
  input  logic [GROUPS-1:0]                   rxPar,
  input  logic                                rxRdy,
  output logic [GROUPS*GROUP_W-1:0]           rxData,
  output logic [GROUPS-1:0]                   rxParErr
);
  localparam int BUS_W = GROUPS * GROUP_W;
  localparam int PAY_W = BUS_W * QP_BEATS;

  logic [PAY_W-1:0] payReg;
  logic [BUS_W-1:0] beatWord;
  logic [BUS_W-1:0] encWire;
  logic [GROUPS-1:0] encInv;

  always_ff @(posedge clk) begin
    if (!rstN) payReg <= '0;
    else if (strobe.load) payReg <= payData;
  end

  assign beatWord = payReg[strobe.sel*BUS_W +: BUS_W];

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    qpGroupEnc #(.GROUP_W(GROUP_W)) uEnc (
      .trueBits (beatWord[g*GROUP_W +: GROUP_W]),
      .wireBits (encWire[g*GROUP_W +: GROUP_W]),
      .invert   (encInv[g])
    );

    assign busWire[g*GROUP_W +: GROUP_W] =
      strobe.drive ? encWire[g*GROUP_W +: GROUP_W] : '1;
    assign busInv[g] = strobe.drive & encInv[g];
    assign busPar[g] = ^busWire[g*GROUP_W +: GROUP_W];

    assign rxData[g*GROUP_W +: GROUP_W] =
      rxInv[g] ? rxWire[g*GROUP_W +: GROUP_W] : ~rxWire[g*GROUP_W +: GROUP_W];
    assign rxParErr[g] = rxRdy & (rxPar[g] ^ (^rxWire[g*GROUP_W +: GROUP_W]));
  end
endmodule

// File: rtl/qpDataLink.sv
module qpDataLink
  import qpLinkPkg::*;
#(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 16
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               payValid,
  input  logic [GROUPS*GROUP_W*QP_BEATS-1:0] payData,
  input  logic                               payLast,
  output logic                               payReady,
  output logic [GROUPS*GROUP_W-1:0]          busWire,
  output logic [GROUPS-1:0]                  busInv,
  output logic [GROUPS-1:0]                  busPar,
  output logic                               dataRdy,
  output logic                               busBusy,
  input  logic [GROUPS*GROUP_W-1:0]          rxWire,
  input  logic [GROUPS-1:0]                  rxInv,
  input  logic [GROUPS-1:0]                  rxPar,
  input  logic                               rxRdy,
  output logic [GROUPS*GROUP_W-1:0]          rxData,
  output logic [GROUPS-1:0]                  rxParErr
);
  qpStrobe_t strobe;

  qpLinkCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .payValid (payValid),
    .payLast  (payLast),
    .payReady (payReady),
    .dataRdy  (dataRdy),
    .busBusy  (busBusy),
    .strobe   (strobe)
  );

  qpLinkDatapath #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .payData  (payData),
    .busWire  (busWire),
    .busInv   (busInv),
    .busPar   (busPar),
    .rxWire   (rxWire),
    .rxInv    (rxInv),
    .rxPar    (rxPar),
    .rxRdy    (rxRdy),
    .rxData   (rxData),
    .rxParErr (rxParErr)
  );
endmodule

// File: rtl/qpDataLinkChk.sv
module qpDataLinkChk #(
  parameter int GROUPS  = 4,
  parameter int GROUP_W = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      payValid,
  input logic                      payReady,
  input logic [GROUPS*GROUP_W-1:0] busWire,
  input logic [GROUPS-1:0]         busInv,
  input logic                      dataRdy,
  input logic                      busBusy
);
  // R2: the ready pulse never lasts two beats
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    payReady |=> !payReady);

  // R2: data clocks only start after an accepting edge
  assert_start_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataRdy) |-> $past(payReady && payValid));

  // R7: idle clocks release all wires and flags
  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dataRdy |-> (busWire == '1 && busInv == '0));

  // R8: data never appears outside a busy window
  assert_data_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataRdy |-> busBusy);

  // R8: busy only falls right after a data clock
  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busBusy) |-> $past(dataRdy));

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    // R4, R5: at most half the wires of a group are ever pulled low
    assert_low_minority_R5: assert property (@(posedge clk) disable iff (!rstN)
      dataRdy |-> $countones(busWire[g*GROUP_W +: GROUP_W]) >= GROUP_W / 2);
    // R4: a raised flag carries a strict majority of set true bits
    assert_flag_majority_R4: assert property (@(posedge clk) disable iff (!rstN)
      busInv[g] |-> $countones(busWire[g*GROUP_W +: GROUP_W]) > GROUP_W / 2);
  end
endmodule

bind qpDataLink qpDataLinkChk #(.GROUPS(GROUPS), .GROUP_W(GROUP_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .payValid (payValid),
  .payReady (payReady),
  .busWire  (busWire),
  .busInv   (busInv),
  .dataRdy  (dataRdy),
  .busBusy  (busBusy)
);

// File: tb/tb_qpDataLink.sv
`timescale 1ns/1ps
module tb_qpDataLink;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         payValid = 1'b0;
  logic [255:0] payData = '0;
  logic         payLast = 1'b0;
  logic         payReady;
  logic [63:0]  busWire;
  logic [3:0]   busInv, busPar;
  logic         dataRdy, busBusy;
  logic [63:0]  rxWire, rxData;
  logic [3:0]   rxInv, rxPar, rxParErr;
  logic         rxRdy;
  logic [63:0]  errMask = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  // loopback with optional wire corruption
  assign rxWire = busWire ^ errMask;
  assign rxInv  = busInv;
  assign rxPar  = busPar;
  assign rxRdy  = dataRdy;

  qpDataLink dut (
    .clk(clk), .rstN(rstN), .payValid(payValid), .payData(payData),
    .payLast(payLast), .payReady(payReady), .busWire(busWire),
    .busInv(busInv), .busPar(busPar), .dataRdy(dataRdy), .busBusy(busBusy),
    .rxWire(rxWire), .rxInv(rxInv), .rxPar(rxPar), .rxRdy(rxRdy),
    .rxData(rxData), .rxParErr(rxParErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] grpPattern(input int c, input int sh);
    logic [15:0] m;
    logic [31:0] t;
    m = (c >= 16) ? 16'hFFFF : 16'((32'h1 << c) - 1);
    t = {m, m} << sh;
    return t[31:16];
  endfunction

  function automatic logic [255:0] makePayload(input int seed);
    logic [255:0] p = '0;
    for (int k = 0; k < 4; k++)
      for (int g = 0; g < 4; g++)
        p[k*64 + g*16 +: 16] = grpPattern((seed + 5*k + 3*g) % 17, (seed + g + 7*k) % 16);
    return p;
  endfunction

  // entry and exit: at a negedge where payReady is high
  task automatic runClock(input logic v, input logic [255:0] d, input logic l,
                          input logic expBusy);
    logic [63:0] word, expWire, expData;
    logic [3:0]  expInv, expPar, expErr;
    payValid = v; payData = d; payLast = l;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) payValid = 1'b0;
      word = d[k*64 +: 64];
      for (int g = 0; g < 4; g++) begin
        expInv[g] = v && ($countones(word[g*16 +: 16]) > 8);
        expWire[g*16 +: 16] = !v ? 16'hFFFF :
                              (expInv[g] ? word[g*16 +: 16] : ~word[g*16 +: 16]);
        expPar[g] = ^expWire[g*16 +: 16];
        expErr[g] = v && (^errMask[g*16 +: 16]);
        expData[g*16 +: 16] = expInv[g] ? (expWire[g*16 +: 16] ^ errMask[g*16 +: 16])
                                        : ~(expWire[g*16 +: 16] ^ errMask[g*16 +: 16]);
      end
      chk("R2 payReady beat", 64'(payReady), 64'(k == 3));
      chk(v ? "R3/R5 wires per sub-phase" : "R7 idle wires", busWire, expWire);
      chk("R4 inversion flags", 64'(busInv), 64'(expInv));
      chk("R6 parity", 64'(busPar), 64'(expPar));
      chk("R7 dataRdy", 64'(dataRdy), 64'(v));
      chk("R8 busBusy", 64'(busBusy), 64'(expBusy));
      if (v && errMask == '0) chk("R9 rx restored data", rxData, word);
      if (!v) chk("R9 rx idle decode", rxData, expData);
      chk("R10 rx parity error", 64'(rxParErr), 64'(expErr));
    end
  endtask

  initial begin
    #(20 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs under reset
    chk("R1 reset dataRdy", 64'(dataRdy), 64'd0);
    chk("R1 reset busBusy", 64'(busBusy), 64'd0);
    chk("R1 reset wires", busWire, '1);
    chk("R1 reset flags/parity", 64'({busInv, busPar}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release dataRdy", 64'(dataRdy), 64'd0);
    while (!payReady) @(negedge clk);
    // R2: ready period of four beats
    gap = 0;
    do begin @(negedge clk); gap++; end while (!payReady && gap < 10);
    chk("R2 ready period", 64'(gap), 64'd4);
    chk("R8 busy before transfer", 64'(busBusy), 64'd0);

    // threshold sweep: set-bit count 0..16 in every group/sub-phase
    for (int pc = 0; pc <= 16; pc++) begin
      if (pc == 9) runClock(1'b0, '0, 1'b0, 1'b1);   // R8 inserted idle clock
      runClock(1'b1, makePayload(pc), pc == 16, 1'b1);
    end
    runClock(1'b0, '0, 1'b0, 1'b0);                  // R8 released after last

    // R4 exact boundary: 8 set bits stays, 9 flips
    runClock(1'b1, {64'h00FF_01FF_FF00_FF80, 64'h0, 64'hFFFF_0000_0F0F_1FF0, 64'h8001_7FFE_0000_FFFF},
             1'b1, 1'b1);
    runClock(1'b0, '0, 1'b0, 1'b0);

    // R10: corrupt one wire of group 2
    errMask = 64'h1 << 37;
    runClock(1'b1, makePayload(3), 1'b1, 1'b1);
    runClock(1'b0, '0, 1'b0, 1'b0);                  // rxRdy low: no error
    errMask = '0;

    // R8: back-to-back final payloads keep busy high
    runClock(1'b1, makePayload(11), 1'b1, 1'b1);
    runClock(1'b1, makePayload(12), 1'b1, 1'b1);
    runClock(1'b0, '0, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule